// File: doc/BRIEF.md
# Dual-Master Code-Region Crossbar

This block sits between two AHB-Lite masters, one fetching instructions and one moving data, and two AHB-Lite slaves that live in the code address region: a flash array in the lower half and an SRAM in the upper half. Each master sees a single ordinary AHB-Lite slave port. Each memory sees a single ordinary AHB-Lite master. Inside, every slave port has its own arbiter. Traffic to different memories therefore flows in the same cycle, and only a collision on one memory costs wait states.

In a collision the data master wins. The instruction master's address phase has already completed on its own bus, so the crossbar stores that address phase. It holds the instruction master in its data phase with HREADY low, and replays the stored request to the memory as soon as that memory finishes its current transfer. An address outside the code region never reaches a memory. A small built-in responder answers it with the standard two-cycle ERROR.

Top module: `code_xbar`

## Requirements
- R1: After reset both masters see hready high and hresp low, and neither slave sees an active transfer (htrans = 2'b00).
- R2: An address with bits 31:29 zero and bit 28 zero is sent to the flash port; the flash port only ever carries such addresses.
- R3: An address with bits 31:29 zero and bit 28 one is sent to the SRAM port; the SRAM port only ever carries such addresses.
- R4: Write data from the data master reaches the slave during that slave's data phase for the write. A word written by the data master can be read back by either master.
- R5: When the two masters address different slaves in the same cycle, both transfers run at the same time. With zero-wait slaves each completes one cycle after its address phase.
- R6: When both masters address the same slave in the same cycle, the data master is accepted first. The instruction transfer completes one slave data phase later. A slave accepts at most one master per cycle.
- R7: The losing master sees hready low until its stored request has been served. The stored address is replayed even after the master has moved its bus to other values. Every transfer reaches a slave as NONSEQ (htrans = 2'b10).
- R8: An address with any of bits 31:29 set gets an error response: hready low with hresp high for one cycle, then hready and hresp both high. No slave sees the transfer.
- R9: A slave's data-phase owner changes only in a cycle where that slave's hreadyout is high. Slave wait states therefore lengthen the owner's data phase and delay a waiting master by the same amount.
- R10: Read data and hresp from each slave go only to the master that owns that slave's data phase, even when the two slaves complete in different cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| d_haddr | input | 32 | Data master address |
| d_htrans | input | 2 | Data master transfer type |
| d_hwrite | input | 1 | Data master write strobe |
| d_hsize | input | 3 | Data master transfer size |
| d_hwdata | input | 32 | Data master write data |
| d_hrdata | output | 32 | Read data to data master |
| d_hready | output | 1 | Ready to data master |
| d_hresp | output | 1 | Error response to data master |
| i_haddr | input | 32 | Instruction master address |
| i_htrans | input | 2 | Instruction master transfer type |
| i_hsize | input | 3 | Instruction master transfer size |
| i_hrdata | output | 32 | Read data to instruction master |
| i_hready | output | 1 | Ready to instruction master |
| i_hresp | output | 1 | Error response to instruction master |
| f_haddr | output | 32 | Flash address |
| f_htrans | output | 2 | Flash transfer type |
| f_hwrite | output | 1 | Flash write strobe |
| f_hsize | output | 3 | Flash transfer size |
| f_hwdata | output | 32 | Flash write data |
| f_hready | output | 1 | Ready input for flash |
| f_hrdata | input | 32 | Flash read data |
| f_hreadyout | input | 1 | Flash ready output |
| f_hresp | input | 1 | Flash error response |
| s_haddr | output | 32 | SRAM address |
| s_htrans | output | 2 | SRAM transfer type |
| s_hwrite | output | 1 | SRAM write strobe |
| s_hsize | output | 3 | SRAM transfer size |
| s_hwdata | output | 32 | SRAM write data |
| s_hready | output | 1 | Ready input for SRAM |
| s_hrdata | input | 32 | SRAM read data |
| s_hreadyout | input | 1 | SRAM ready output |
| s_hresp | input | 1 | SRAM error response |

## Verification
The bench builds the crossbar with its default parameters: region boundary at bit 29, slave select on bit 28, two masters and two slaves. This covers both decode halves, the out-of-region responder and every pairing of master and slave. Its memory models take a wait-state count that the bench can change at run time. With waits of 0, 1 and 2 cycles it reaches three cases: contention stretched by slave waits, parallel completions in different cycles, and replay of a stored request after the master has changed its bus.

// File: rtl/code_xbar_pkg.sv
package code_xbar_pkg;

    localparam int AW     = 32;
    localparam int DW     = 32;
    localparam int NM     = 2;
    localparam int NS     = 2;
    localparam int SW     = (NS > 1) ? $clog2(NS) : 1;
    localparam int MW     = (NM > 1) ? $clog2(NM) : 1;
    localparam int MI_DATA  = 0;
    localparam int MI_INSN  = 1;
    localparam int SI_FLASH = 0;
    localparam int SI_SRAM  = 1;

    typedef enum logic [2:0] {
        MS_IDLE,
        MS_HOLD,
        MS_SLV,
        MS_ERR1,
        MS_ERR2
    } mst_state_e;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic          write;
        logic [2:0]    size;
    } req_t;

endpackage

// File: rtl/code_xbar_mst.sv
module code_xbar_mst
    import code_xbar_pkg::*;
#(
    parameter int REGION_LSB = 29,
    parameter int SEL_BIT    = 28
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [AW-1:0]          haddr,
    input  logic [1:0]             htrans,
    input  logic                   hwrite,
    input  logic [2:0]             hsize,
    output logic                   hready,
    output logic                   hresp,
    output logic [DW-1:0]          hrdata,
    output logic                   req_vld,
    output logic [SW-1:0]          req_sel,
    output req_t                   req,
    input  logic [NS-1:0]          accept,
    input  logic [NS-1:0]          slv_ready,
    input  logic [NS-1:0]          slv_resp,
    input  logic [NS-1:0][DW-1:0]  slv_rdata
);

    typedef struct packed {
        mst_state_e    st;
        logic [SW-1:0] sel;
        req_t          hold;
        logic [SW-1:0] hold_sel;
    } mst_regs_t;

    mst_regs_t r_q, r_d;
    logic      live;
    logic      in_reg;

    always_comb begin
        r_d    = r_q;
        hready = 1'b1;
        hresp  = 1'b0;
        hrdata = '0;

        // response seen by the master in its current data phase
        unique case (r_q.st)
            MS_HOLD: hready = 1'b0;
            MS_SLV: begin
                hready = slv_ready[r_q.sel];
                hresp  = slv_resp[r_q.sel];
                hrdata = slv_rdata[r_q.sel];
            end
            MS_ERR1: begin
                hready = 1'b0;
                hresp  = 1'b1;
            end
            MS_ERR2: hresp = 1'b1;
            default: ;
        endcase

        in_reg = (haddr[AW-1:REGION_LSB] == '0);
        live   = htrans[1] && hready;

        // request offered to the slave arbiters
        if (r_q.st == MS_HOLD) begin
            req_vld = 1'b1;
            req_sel = r_q.hold_sel;
            req     = r_q.hold;
        end else begin
            req_vld = live && in_reg;
            req_sel = haddr[SEL_BIT +: SW];
            req     = '{addr: haddr, write: hwrite, size: hsize};
        end

        // state advance
        if (r_q.st == MS_HOLD) begin
            if (accept[r_q.hold_sel]) begin
                r_d.st  = MS_SLV;
                r_d.sel = r_q.hold_sel;
            end
        end else if (r_q.st == MS_ERR1) begin
            r_d.st = MS_ERR2;
        end else if (hready) begin
            if (!live) begin
                r_d.st = MS_IDLE;
            end else if (!in_reg) begin
                r_d.st = MS_ERR1;
            end else if (accept[req_sel]) begin
                r_d.st  = MS_SLV;
                r_d.sel = req_sel;
            end else begin
                r_d.st       = MS_HOLD;
                r_d.hold     = req;
                r_d.hold_sel = req_sel;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: MS_IDLE, sel: '0, hold: '0, hold_sel: '0};
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/code_xbar_slv.sv
module code_xbar_slv
    import code_xbar_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NM-1:0]          req_vld,
    input  logic [NM-1:0][SW-1:0]  req_sel,
    input  req_t [NM-1:0]          req,
    input  logic [NM-1:0][DW-1:0]  mst_wdata,
    input  logic                   hreadyout,
    output logic [NM-1:0]          accept,
    output logic [AW-1:0]          haddr,
    output logic [1:0]             htrans,
    output logic                   hwrite,
    output logic [2:0]             hsize,
    output logic [DW-1:0]          hwdata,
    output logic                   hready,
    output logic                   own_vld,
    output logic [MW-1:0]          own_idx
);

    typedef struct packed {
        logic          vld;
        logic [MW-1:0] idx;
    } own_t;

    own_t          own_q, own_d;
    logic          found;
    logic [MW-1:0] pick;

    always_comb begin
        own_d = own_q;
        found = 1'b0;
        pick  = '0;

        // fixed priority: lowest master index (data master) wins
        for (int m = 0; m < NM; m++) begin
            if (!found && req_vld[m] && (req_sel[m] == SW'(IDX))) begin
                found = 1'b1;
                pick  = MW'(m);
            end
        end

        accept       = '0;
        accept[pick] = found && hreadyout;

        haddr  = found ? req[pick].addr  : '0;
        htrans = found ? 2'b10           : 2'b00;
        hwrite = found ? req[pick].write : 1'b0;
        hsize  = found ? req[pick].size  : 3'b000;
        hready = hreadyout;
        hwdata = own_q.vld ? mst_wdata[own_q.idx] : '0;

        // data-phase ownership moves only on a ready cycle
        if (hreadyout) begin
            own_d.vld = found;
            own_d.idx = pick;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            own_q <= '0;
        end else begin
            own_q <= own_d;
        end
    end

    assign own_vld = own_q.vld;
    assign own_idx = own_q.idx;

endmodule

// File: rtl/code_xbar.sv
module code_xbar
    import code_xbar_pkg::*;
#(
    parameter int REGION_LSB = 29,
    parameter int SEL_BIT    = 28
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] d_haddr,
    input  logic [1:0]    d_htrans,
    input  logic          d_hwrite,
    input  logic [2:0]    d_hsize,
    input  logic [DW-1:0] d_hwdata,
    output logic [DW-1:0] d_hrdata,
    output logic          d_hready,
    output logic          d_hresp,
    input  logic [AW-1:0] i_haddr,
    input  logic [1:0]    i_htrans,
    input  logic [2:0]    i_hsize,
    output logic [DW-1:0] i_hrdata,
    output logic          i_hready,
    output logic          i_hresp,
    output logic [AW-1:0] f_haddr,
    output logic [1:0]    f_htrans,
    output logic          f_hwrite,
    output logic [2:0]    f_hsize,
    output logic [DW-1:0] f_hwdata,
    output logic          f_hready,
    input  logic [DW-1:0] f_hrdata,
    input  logic          f_hreadyout,
    input  logic          f_hresp,
    output logic [AW-1:0] s_haddr,
    output logic [1:0]    s_htrans,
    output logic          s_hwrite,
    output logic [2:0]    s_hsize,
    output logic [DW-1:0] s_hwdata,
    output logic          s_hready,
    input  logic [DW-1:0] s_hrdata,
    input  logic          s_hreadyout,
    input  logic          s_hresp
);

    logic [NM-1:0][AW-1:0]  m_haddr;
    logic [NM-1:0][1:0]     m_htrans;
    logic [NM-1:0]          m_hwrite;
    logic [NM-1:0][2:0]     m_hsize;
    logic [NM-1:0][DW-1:0]  m_hwdata;
    logic [NM-1:0][DW-1:0]  m_hrdata;
    logic [NM-1:0]          m_hready;
    logic [NM-1:0]          m_hresp;

    logic [NS-1:0]          sl_ready;
    logic [NS-1:0]          sl_resp;
    logic [NS-1:0][DW-1:0]  sl_rdata;
    logic [NS-1:0][AW-1:0]  sl_haddr;
    logic [NS-1:0][1:0]     sl_htrans;
    logic [NS-1:0]          sl_hwrite;
    logic [NS-1:0][2:0]     sl_hsize;
    logic [NS-1:0][DW-1:0]  sl_hwdata;
    logic [NS-1:0]          sl_hready;

    logic [NM-1:0]          req_vld;
    logic [NM-1:0][SW-1:0]  req_sel;
    req_t [NM-1:0]          req;
    logic [NS-1:0][NM-1:0]  acc_by_slv;
    logic [NM-1:0][NS-1:0]  acc_by_mst;
    logic [NS-1:0]          own_vld;
    logic [NS-1:0][MW-1:0]  own_idx;

    // master side packing
    assign m_haddr[MI_DATA]  = d_haddr;
    assign m_htrans[MI_DATA] = d_htrans;
    assign m_hwrite[MI_DATA] = d_hwrite;
    assign m_hsize[MI_DATA]  = d_hsize;
    assign m_hwdata[MI_DATA] = d_hwdata;
    assign m_haddr[MI_INSN]  = i_haddr;
    assign m_htrans[MI_INSN] = i_htrans;
    assign m_hwrite[MI_INSN] = 1'b0;
    assign m_hsize[MI_INSN]  = i_hsize;
    assign m_hwdata[MI_INSN] = '0;

    assign d_hrdata = m_hrdata[MI_DATA];
    assign d_hready = m_hready[MI_DATA];
    assign d_hresp  = m_hresp[MI_DATA];
    assign i_hrdata = m_hrdata[MI_INSN];
    assign i_hready = m_hready[MI_INSN];
    assign i_hresp  = m_hresp[MI_INSN];

    // slave side packing
    assign sl_ready[SI_FLASH] = f_hreadyout;
    assign sl_resp[SI_FLASH]  = f_hresp;
    assign sl_rdata[SI_FLASH] = f_hrdata;
    assign sl_ready[SI_SRAM]  = s_hreadyout;
    assign sl_resp[SI_SRAM]   = s_hresp;
    assign sl_rdata[SI_SRAM]  = s_hrdata;

    assign f_haddr  = sl_haddr[SI_FLASH];
    assign f_htrans = sl_htrans[SI_FLASH];
    assign f_hwrite = sl_hwrite[SI_FLASH];
    assign f_hsize  = sl_hsize[SI_FLASH];
    assign f_hwdata = sl_hwdata[SI_FLASH];
    assign f_hready = sl_hready[SI_FLASH];
    assign s_haddr  = sl_haddr[SI_SRAM];
    assign s_htrans = sl_htrans[SI_SRAM];
    assign s_hwrite = sl_hwrite[SI_SRAM];
    assign s_hsize  = sl_hsize[SI_SRAM];
    assign s_hwdata = sl_hwdata[SI_SRAM];
    assign s_hready = sl_hready[SI_SRAM];

    for (genvar m = 0; m < NM; m++) begin : g_acc_m
        for (genvar s = 0; s < NS; s++) begin : g_acc_s
            assign acc_by_mst[m][s] = acc_by_slv[s][m];
        end
    end

    for (genvar m = 0; m < NM; m++) begin : g_mst
        code_xbar_mst #(
            .REGION_LSB (REGION_LSB),
            .SEL_BIT    (SEL_BIT)
        ) u_mst (
            .clk       (clk),
            .rst_n     (rst_n),
            .haddr     (m_haddr[m]),
            .htrans    (m_htrans[m]),
            .hwrite    (m_hwrite[m]),
            .hsize     (m_hsize[m]),
            .hready    (m_hready[m]),
            .hresp     (m_hresp[m]),
            .hrdata    (m_hrdata[m]),
            .req_vld   (req_vld[m]),
            .req_sel   (req_sel[m]),
            .req       (req[m]),
            .accept    (acc_by_mst[m]),
            .slv_ready (sl_ready),
            .slv_resp  (sl_resp),
            .slv_rdata (sl_rdata)
        );
    end

    for (genvar s = 0; s < NS; s++) begin : g_slv
        code_xbar_slv #(
            .IDX (s)
        ) u_slv (
            .clk       (clk),
            .rst_n     (rst_n),
            .req_vld   (req_vld),
            .req_sel   (req_sel),
            .req       (req),
            .mst_wdata (m_hwdata),
            .hreadyout (sl_ready[s]),
            .accept    (acc_by_slv[s]),
            .haddr     (sl_haddr[s]),
            .htrans    (sl_htrans[s]),
            .hwrite    (sl_hwrite[s]),
            .hsize     (sl_hsize[s]),
            .hwdata    (sl_hwdata[s]),
            .hready    (sl_hready[s]),
            .own_vld   (own_vld[s]),
            .own_idx   (own_idx[s])
        );
    end

endmodule

// File: rtl/code_xbar_chk.sv
module code_xbar_chk
    import code_xbar_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input logic                   d_hready,
    input logic                   d_hresp,
    input logic                   i_hready,
    input logic                   i_hresp,
    input logic [1:0]             f_htrans,
    input logic [AW-1:0]          f_haddr,
    input logic [1:0]             s_htrans,
    input logic [AW-1:0]          s_haddr,
    input logic                   f_hreadyout,
    input logic                   s_hreadyout,
    input logic [NS-1:0]          own_vld,
    input logic [NS-1:0][MW-1:0]  own_idx,
    input logic [NS-1:0][NM-1:0]  acc
);

    p_flash_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        f_htrans[1] |-> (f_haddr[31:28] == 4'h0));

    p_sram_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        s_htrans[1] |-> (s_haddr[31:28] == 4'h1));

    p_one_accept_flash_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(acc[SI_FLASH]));

    p_one_accept_sram_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(acc[SI_SRAM]));

    p_err_second_d_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (d_hresp && !d_hready) |=> (d_hresp && d_hready));

    p_err_second_i_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (i_hresp && !i_hready) |=> (i_hresp && i_hready));

    p_flash_owner_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !f_hreadyout |=> ($stable(own_vld[SI_FLASH]) && $stable(own_idx[SI_FLASH])));

    p_sram_owner_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !s_hreadyout |=> ($stable(own_vld[SI_SRAM]) && $stable(own_idx[SI_SRAM])));

endmodule

bind code_xbar code_xbar_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .d_hready    (d_hready),
    .d_hresp     (d_hresp),
    .i_hready    (i_hready),
    .i_hresp     (i_hresp),
    .f_htrans    (f_htrans),
    .f_haddr     (f_haddr),
    .s_htrans    (s_htrans),
    .s_haddr     (s_haddr),
    .f_hreadyout (f_hreadyout),
    .s_hreadyout (s_hreadyout),
    .own_vld     (own_vld),
    .own_idx     (own_idx),
    .acc         (acc_by_slv)
);

// File: tb/code_xbar_test.sv
module code_xbar_test_mem #(
    parameter logic [15:0] TAG = 16'h0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] haddr,
    input  logic [1:0]  htrans,
    input  logic        hwrite,
    input  logic [31:0] hwdata,
    input  logic        hready,
    input  logic [3:0]  ws,
    output logic [31:0] hrdata,
    output logic        hreadyout,
    output logic        hresp,
    output int          acc_cnt
);
    logic [31:0] mem [256];
    logic        dp;
    logic [7:0]  a_q;
    logic        w_q;
    logic [3:0]  cnt;

    initial begin
        for (int k = 0; k < 256; k++) mem[k] = {TAG, 8'h00, k[7:0]};
    end

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp <= 1'b0; a_q <= '0; w_q <= 1'b0; cnt <= '0; acc_cnt <= 0;
        end else if (hready) begin
            if (dp && w_q) mem[a_q] <= hwdata;
            dp  <= htrans[1];
            a_q <= haddr[9:2];
            w_q <= hwrite;
            cnt <= ws;
            if (htrans[1]) acc_cnt <= acc_cnt + 1;
        end else if (cnt != 0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign hreadyout = !dp || (cnt == 0);
    assign hrdata    = (dp && !w_q) ? mem[a_q] : 32'h0;
    assign hresp     = 1'b0;
endmodule

module code_xbar_test;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [31:0] data;
        logic        err;
        logic        chk;
        string       req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic [31:0] m_addr  [2];
    logic [1:0]  m_trans [2];
    logic        m_write [2];
    logic [2:0]  m_size  [2];
    logic [31:0] m_wdata [2];
    logic [31:0] mh_rdata[2];
    logic        mh_ready[2];
    logic        mh_resp [2];

    logic [31:0] f_haddr, s_haddr, f_hwdata, s_hwdata, f_hrdata, s_hrdata;
    logic [1:0]  f_htrans, s_htrans;
    logic [2:0]  f_hsize, s_hsize;
    logic        f_hwrite, s_hwrite, f_hready, s_hready;
    logic        f_hreadyout, s_hreadyout, f_hresp, s_hresp;
    logic [3:0]  f_ws = 4'd0;
    logic [3:0]  s_ws = 4'd0;
    int          f_acc, s_acc;

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;
    int pend    [2] = '{0, 0};
    int iss_cyc [2] = '{0, 0};
    int lat     [2] = '{0, 0};
    int done_cyc[2] = '{0, 0};
    bit finished = 1'b0;
    exp_t q_d[$];
    exp_t q_i[$];

    code_xbar uut (
        .clk(clk), .rst_n(rst_n),
        .d_haddr(m_addr[0]), .d_htrans(m_trans[0]), .d_hwrite(m_write[0]),
        .d_hsize(m_size[0]), .d_hwdata(m_wdata[0]), .d_hrdata(mh_rdata[0]),
        .d_hready(mh_ready[0]), .d_hresp(mh_resp[0]),
        .i_haddr(m_addr[1]), .i_htrans(m_trans[1]), .i_hsize(m_size[1]),
        .i_hrdata(mh_rdata[1]), .i_hready(mh_ready[1]), .i_hresp(mh_resp[1]),
        .f_haddr(f_haddr), .f_htrans(f_htrans), .f_hwrite(f_hwrite), .f_hsize(f_hsize),
        .f_hwdata(f_hwdata), .f_hready(f_hready), .f_hrdata(f_hrdata),
        .f_hreadyout(f_hreadyout), .f_hresp(f_hresp),
        .s_haddr(s_haddr), .s_htrans(s_htrans), .s_hwrite(s_hwrite), .s_hsize(s_hsize),
        .s_hwdata(s_hwdata), .s_hready(s_hready), .s_hrdata(s_hrdata),
        .s_hreadyout(s_hreadyout), .s_hresp(s_hresp)
    );

    code_xbar_test_mem #(.TAG(16'hF1A5)) u_flash (
        .clk(clk), .rst_n(rst_n), .haddr(f_haddr), .htrans(f_htrans), .hwrite(f_hwrite),
        .hwdata(f_hwdata), .hready(f_hready), .ws(f_ws), .hrdata(f_hrdata),
        .hreadyout(f_hreadyout), .hresp(f_hresp), .acc_cnt(f_acc));

    code_xbar_test_mem #(.TAG(16'h5A3C)) u_sram (
        .clk(clk), .rst_n(rst_n), .haddr(s_haddr), .htrans(s_htrans), .hwrite(s_hwrite),
        .hwdata(s_hwdata), .hready(s_hready), .ws(s_ws), .hrdata(s_hrdata),
        .hreadyout(s_hreadyout), .hresp(s_hresp), .acc_cnt(s_acc));

    function automatic logic [31:0] fpat(input logic [31:0] a);
        return {16'hF1A5, 8'h00, a[9:2]};
    endfunction

    function automatic logic [31:0] spat(input logic [31:0] a);
        return {16'h5A3C, 8'h00, a[9:2]};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pops the expected item when a data phase completes
    always @(negedge clk) begin
        if (rst_n) begin
            for (int m = 0; m < 2; m++) begin
                if (pend[m] != 0 && mh_ready[m]) begin
                    exp_t e;
                    pend[m]     = 0;
                    done_cyc[m] = cyc;
                    lat[m]      = cyc - iss_cyc[m];
                    if ((m == 0 && q_d.size() == 0) || (m == 1 && q_i.size() == 0)) begin
                        check(1'b0, "R10", "unexpected completion", 32'h1, 32'h0);
                    end else begin
                        e = (m == 0) ? q_d.pop_front() : q_i.pop_front();
                        check(mh_resp[m] == e.err, e.req, "hresp",
                              {31'h0, mh_resp[m]}, {31'h0, e.err});
                        if (e.chk)
                            check(mh_rdata[m] == e.data, e.req, "hrdata", mh_rdata[m], e.data);
                    end
                end
                if (m_trans[m][1] && mh_ready[m]) begin
                    pend[m]    = 1;
                    iss_cyc[m] = cyc;
                end
            end
        end
    end

    // driver: one non-pipelined transfer, expected result queued first
    task automatic xfer(input int m, input logic [31:0] a, input logic w,
                        input logic [31:0] wd, input logic [31:0] exp,
                        input logic experr, input string req);
        exp_t e;
        e.data = exp; e.err = experr; e.chk = !w && !experr; e.req = req;
        if (m == 0) q_d.push_back(e); else q_i.push_back(e);
        @(posedge clk); #1;
        m_addr[m] = a; m_trans[m] = 2'b10; m_write[m] = w; m_size[m] = 3'b010;
        do @(negedge clk); while (!mh_ready[m]);
        @(posedge clk); #1;
        m_trans[m] = 2'b00; m_addr[m] = 32'hDEAD_BEE0; m_write[m] = 1'b0;
        m_wdata[m] = wd;
        do @(negedge clk); while (!mh_ready[m]);
        @(posedge clk); #1;
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
    end

    initial begin
        int fa0, sa0;
        for (int m = 0; m < 2; m++) begin
            m_addr[m] = '0; m_trans[m] = '0; m_write[m] = 1'b0;
            m_size[m] = 3'b010; m_wdata[m] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(mh_ready[0] && mh_ready[1], "R1", "hready after reset",
              {30'h0, mh_ready[1], mh_ready[0]}, 32'h3);
        check(!mh_resp[0] && !mh_resp[1], "R1", "hresp after reset",
              {30'h0, mh_resp[1], mh_resp[0]}, 32'h0);
        check(f_htrans == 2'b00 && s_htrans == 2'b00, "R1", "slave htrans",
              {28'h0, f_htrans, s_htrans}, 32'h0);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(mh_ready[0] && mh_ready[1], "R1", "hready after release",
              {30'h0, mh_ready[1], mh_ready[0]}, 32'h3);

        // R2 / R3 decode of each half
        xfer(0, 32'h0000_0040, 1'b0, '0, fpat(32'h40), 1'b0, "R2");
        check(lat[0] == 1, "R2", "flash read latency", lat[0], 1);
        xfer(0, 32'h1000_0080, 1'b0, '0, spat(32'h80), 1'b0, "R3");
        xfer(1, 32'h0FFF_FF04, 1'b0, '0, fpat(32'h0FFF_FF04), 1'b0, "R2");
        xfer(1, 32'h1FFF_FF08, 1'b0, '0, spat(32'h1FFF_FF08), 1'b0, "R3");

        // R4 write data reaches the slave
        xfer(0, 32'h1000_0100, 1'b1, 32'h1234_5678, '0, 1'b0, "R4");
        xfer(1, 32'h1000_0100, 1'b0, '0, 32'h1234_5678, 1'b0, "R4");
        xfer(0, 32'h0000_0200, 1'b1, 32'hCAFE_0001, '0, 1'b0, "R4");
        xfer(0, 32'h0000_0200, 1'b0, '0, 32'hCAFE_0001, 1'b0, "R4");

        // R5 different slaves in parallel
        fork
            xfer(0, 32'h1000_0004, 1'b0, '0, spat(32'h4), 1'b0, "R5");
            xfer(1, 32'h0000_0008, 1'b0, '0, fpat(32'h8), 1'b0, "R5");
        join
        check(lat[0] == 1 && lat[1] == 1, "R5", "parallel latencies",
              {lat[0][15:0], lat[1][15:0]}, 32'h0001_0001);
        check(done_cyc[0] == done_cyc[1], "R5", "same completion cycle",
              done_cyc[0], done_cyc[1]);

        // R6 / R7 same slave: data first, instruction replayed later
        fork
            xfer(0, 32'h0000_000C, 1'b0, '0, fpat(32'hC), 1'b0, "R6");
            xfer(1, 32'h0000_0010, 1'b0, '0, fpat(32'h10), 1'b0, "R7");
        join
        check(lat[0] == 1, "R6", "data master latency", lat[0], 1);
        check(lat[1] == 2, "R7", "held instruction latency", lat[1], 2);

        fork
            xfer(0, 32'h1000_0140, 1'b1, 32'hA5A5_0F0F, '0, 1'b0, "R6");
            xfer(1, 32'h1000_0144, 1'b0, '0, spat(32'h144), 1'b0, "R7");
        join
        check(done_cyc[1] == done_cyc[0] + 1, "R6", "sram order",
              done_cyc[1], done_cyc[0] + 1);
        xfer(1, 32'h1000_0140, 1'b0, '0, 32'hA5A5_0F0F, 1'b0, "R4");

        // R9 wait states lengthen owner and delay the held master
        f_ws = 4'd2;
        fork
            xfer(0, 32'h0000_0014, 1'b0, '0, fpat(32'h14), 1'b0, "R9");
            xfer(1, 32'h0000_0018, 1'b0, '0, fpat(32'h18), 1'b0, "R9");
        join
        check(lat[0] == 3, "R9", "waited data latency", lat[0], 3);
        check(lat[1] == 6, "R9", "held behind waits", lat[1], 6);
        f_ws = 4'd0;

        // R10 routing with completions in different cycles
        s_ws = 4'd1;
        fork
            xfer(0, 32'h1000_0020, 1'b0, '0, spat(32'h20), 1'b0, "R10");
            xfer(1, 32'h0000_0024, 1'b0, '0, fpat(32'h24), 1'b0, "R10");
        join
        check(lat[0] == 2 && lat[1] == 1, "R10", "split completion",
              {lat[0][15:0], lat[1][15:0]}, 32'h0002_0001);
        s_ws = 4'd0;

        // R8 out-of-region error, no slave access
        fa0 = f_acc; sa0 = s_acc;
        xfer(0, 32'h2000_0000, 1'b0, '0, '0, 1'b1, "R8");
        check(lat[0] == 2, "R8", "error length", lat[0], 2);
        fork
            xfer(1, 32'hE000_0010, 1'b0, '0, '0, 1'b1, "R8");
            xfer(0, 32'h0000_0030, 1'b0, '0, fpat(32'h30), 1'b0, "R10");
        join
        check(lat[1] == 2, "R8", "instruction error length", lat[1], 2);
        check(f_acc == fa0 + 1 && s_acc == sa0, "R8", "slave accesses",
              f_acc - fa0 + (s_acc - sa0), 1);

        repeat (3) @(posedge clk);
        check(q_d.size() == 0 && q_i.size() == 0, "R10", "outstanding items",
              q_d.size() + q_i.size(), 0);
        summary();
    end

endmodule